// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox

This block carries short command words between two ports that run on unrelated clocks, with no use of the data queue. It holds two 36-bit registers. The forward register takes a word written on port A and offers it to port B. The return register takes a word written on port B and offers it to port A. Each register has an active-LOW "full" flag. Only the writer may load a register. The flag then goes LOW, and it stays LOW until the reader has taken the word.

Each port has a mailbox-select input. When the select is HIGH, an enabled write goes to the register and an enabled read acknowledges it. The select also controls the port's output multiplexer. With the select HIGH, the port shows the mailbox word. With the select LOW, the port shows the word from its FIFO output register, which the surrounding queue supplies.

The flag crosses between the clock domains as a toggle request and a toggle acknowledge, each through two flip-flops. A static bus-size input narrows the usable mailbox width to 36, 18 or 9 bits.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, all four full flags are HIGH, and both mailbox registers read as zero.
- R2: An enabled write with the mailbox select HIGH, made while the writer's flag is HIGH, stores the word. The writer's flag is LOW after that writer clock edge.
- R3: A write attempted while the writer's flag is LOW is ignored, and the stored word is kept.
- R4: The reader's flag goes LOW within three reader clock edges after an accepted write.
- R5: An enabled read with the mailbox select HIGH, made while the reader's flag is LOW, sets the reader's flag HIGH at that edge. The writer's flag goes HIGH within three writer clock edges after it.
- R6: A read does not change the stored word. It stays on the output after the read.
- R7: When mailbox select is LOW, the port output equals the port's FIFO output word.
- R8: Bus size is encoded as 00 for 36 bits, 01 for 18 bits, and 10 or 11 for 9 bits. In the narrow modes, only bits 17:0 or 8:0 are stored and shown. Higher input bits are ignored, and higher output bits read as zero.
- R9: Assertion of reset while a word is held returns both flags of that path HIGH and clears the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-LOW reset for both domains |
| bus_size | input | 2 | Mailbox width select (static) |
| a_en | input | 1 | Port A transfer enable |
| a_write | input | 1 | Port A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Port A FIFO output word |
| a_dout | output | 36 | Port A output data |
| a_fwd_full_n | output | 1 | Forward register flag, port A view |
| a_ret_full_n | output | 1 | Return register flag, port A view |
| b_en | input | 1 | Port B transfer enable |
| b_write | input | 1 | Port B direction: 1 write, 0 read |
| b_mbsel | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Port B FIFO output word |
| b_dout | output | 36 | Port B output data |
| b_fwd_full_n | output | 1 | Forward register flag, port B view |
| b_ret_full_n | output | 1 | Return register flag, port B view |

## Verification
The assertions rely on two assumptions. First, bus_size does not change while a word is held. Second, the reset is released only with both clocks running. The stimulus changes the size only while both registers are empty, and it drives every input on falling edges. Reads on the receiving port are issued only after that port's flag has gone LOW. Writes into a full register are issued on purpose, so that the lockout is exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_W = 36;

  typedef enum logic [1:0] {
    BSZ_FULL = 2'b00,
    BSZ_HALF = 2'b01,
    BSZ_BYTE = 2'b10,
    BSZ_BYT2 = 2'b11
  } bsz_e;

  function automatic logic [MBX_W-1:0] lane_mask(input logic [1:0] sz);
    logic [MBX_W-1:0] m;
    case (sz)
      2'b00:   m = '1;
      2'b01:   m = {{(MBX_W-18){1'b0}}, {18{1'b1}}};
      default: m = {{(MBX_W-9){1'b0}}, {9{1'b1}}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned W = 36
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] data_q,
  output logic         wr_full_n,
  output logic         rd_full_n,
  output logic         wr_acc,
  output logic         rd_acc
);
  logic put_tog, ack_tog;
  logic put_seen, ack_seen;

  // writer domain: register plus request toggle
  assign wr_full_n = (put_tog == ack_seen);
  assign wr_acc    = wr_req & wr_full_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      put_tog <= 1'b0;
    end else if (wr_acc) begin
      data_q  <= wr_data;
      put_tog <= ~put_tog;
    end
  end

  mbx_sync2 #(.STAGES(2)) u_put_sync (
    .clk(rclk), .rst_n(rst_n), .d(put_tog), .q(put_seen)
  );

  // reader domain: acknowledge toggle
  assign rd_full_n = (put_seen == ack_tog);
  assign rd_acc    = rd_req & ~rd_full_n;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      ack_tog <= 1'b0;
    else if (rd_acc) ack_tog <= ~ack_tog;
  end

  mbx_sync2 #(.STAGES(2)) u_ack_sync (
    .clk(wclk), .rst_n(rst_n), .d(ack_tog), .q(ack_seen)
  );
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned W = MBX_W
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic [1:0]   bus_size,
  input  logic         a_en,
  input  logic         a_write,
  input  logic         a_mbsel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         a_fwd_full_n,
  output logic         a_ret_full_n,
  input  logic         b_en,
  input  logic         b_write,
  input  logic         b_mbsel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_fwd_full_n,
  output logic         b_ret_full_n
);
  localparam int unsigned NPATH = 2;

  logic [W-1:0] msk;
  logic         a_wr_req, a_rd_req, b_wr_req, b_rd_req;

  logic [NPATH-1:0]        p_wclk, p_rclk, p_wreq, p_rreq;
  logic [NPATH-1:0]        p_wfull_n, p_rfull_n, p_wacc, p_racc;
  logic [NPATH-1:0][W-1:0] p_wdata, p_q;

  assign msk      = W'(lane_mask(bus_size));
  assign a_wr_req = a_en &  a_write & a_mbsel;
  assign a_rd_req = a_en & ~a_write & a_mbsel;
  assign b_wr_req = b_en &  b_write & b_mbsel;
  assign b_rd_req = b_en & ~b_write & b_mbsel;

  // path 0: A -> B, path 1: B -> A
  assign p_wclk  = {clk_b, clk_a};
  assign p_rclk  = {clk_a, clk_b};
  assign p_wreq  = {b_wr_req, a_wr_req};
  assign p_rreq  = {a_rd_req, b_rd_req};
  assign p_wdata = {b_din & msk, a_din & msk};

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    mbx_slot #(.W(W)) u_slot (
      .wclk(p_wclk[i]), .rclk(p_rclk[i]), .rst_n(rst_n),
      .wr_req(p_wreq[i]), .wr_data(p_wdata[i]), .rd_req(p_rreq[i]),
      .data_q(p_q[i]), .wr_full_n(p_wfull_n[i]), .rd_full_n(p_rfull_n[i]),
      .wr_acc(p_wacc[i]), .rd_acc(p_racc[i])
    );
  end

  assign a_fwd_full_n = p_wfull_n[0];
  assign b_fwd_full_n = p_rfull_n[0];
  assign b_ret_full_n = p_wfull_n[1];
  assign a_ret_full_n = p_rfull_n[1];

  assign b_dout = b_mbsel ? (p_q[0] & msk) : b_fifo_q;
  assign a_dout = a_mbsel ? (p_q[1] & msk) : a_fifo_q;
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic [1:0]   bus_size,
  input logic         a_mbsel,
  input logic         b_mbsel,
  input logic [W-1:0] a_fifo_q,
  input logic [W-1:0] b_fifo_q,
  input logic [W-1:0] a_dout,
  input logic [W-1:0] b_dout,
  input logic         fwd_wacc,
  input logic         fwd_racc,
  input logic         fwd_wfull_n,
  input logic         fwd_rfull_n,
  input logic         fwd_req,
  input logic [W-1:0] fwd_q,
  input logic         ret_wacc,
  input logic         ret_racc,
  input logic         ret_wfull_n,
  input logic         ret_rfull_n,
  input logic [W-1:0] ret_q
);
  AST_FWD_FLAG_LOW: assert property (@(posedge clk_a) disable iff (!rst_n)
    fwd_wacc |=> !fwd_wfull_n); // R2
  AST_RET_FLAG_LOW: assert property (@(posedge clk_b) disable iff (!rst_n)
    ret_wacc |=> !ret_wfull_n); // R2
  AST_FWD_LOCKOUT: assert property (@(posedge clk_a) disable iff (!rst_n)
    (fwd_req && !fwd_wfull_n) |=> $stable(fwd_q)); // R3
  AST_FWD_RD_RELEASE: assert property (@(posedge clk_b) disable iff (!rst_n)
    fwd_racc |=> fwd_rfull_n); // R5
  AST_RET_RD_RELEASE: assert property (@(posedge clk_a) disable iff (!rst_n)
    ret_racc |=> ret_rfull_n); // R5
  AST_FWD_KEEP: assert property (@(posedge clk_a) disable iff (!rst_n)
    !fwd_wacc |=> $stable(fwd_q)); // R6
  AST_RET_KEEP: assert property (@(posedge clk_b) disable iff (!rst_n)
    !ret_wacc |=> $stable(ret_q)); // R6
  AST_A_STEER: assert property (@(negedge clk_a) disable iff (!rst_n)
    !a_mbsel |-> (a_dout == a_fifo_q)); // R7
  AST_B_STEER: assert property (@(negedge clk_b) disable iff (!rst_n)
    !b_mbsel |-> (b_dout == b_fifo_q)); // R7
  AST_BYTE_LANES: assert property (@(negedge clk_b) disable iff (!rst_n)
    (b_mbsel && bus_size[1]) |-> (b_dout[W-1:9] == '0)); // R8
  AST_HALF_LANES: assert property (@(negedge clk_a) disable iff (!rst_n)
    (a_mbsel && bus_size == 2'b01) |-> (a_dout[W-1:18] == '0)); // R8
endmodule

bind mbx_bridge mbx_bridge_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .bus_size(bus_size),
  .a_mbsel(a_mbsel), .b_mbsel(b_mbsel), .a_fifo_q(a_fifo_q), .b_fifo_q(b_fifo_q),
  .a_dout(a_dout), .b_dout(b_dout),
  .fwd_wacc(p_wacc[0]), .fwd_racc(p_racc[0]), .fwd_wfull_n(p_wfull_n[0]),
  .fwd_rfull_n(p_rfull_n[0]), .fwd_req(a_wr_req), .fwd_q(p_q[0]),
  .ret_wacc(p_wacc[1]), .ret_racc(p_racc[1]), .ret_wfull_n(p_wfull_n[1]),
  .ret_rfull_n(p_rfull_n[1]), .ret_q(p_q[1])
);

// File: tb/mbx_bridge_test.sv
module mbx_bridge_test;
  localparam int unsigned W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_size = 2'b00;
  logic a_en = 0, a_write = 0, a_mbsel = 0, b_en = 0, b_write = 0, b_mbsel = 0;
  logic [W-1:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_fwd_full_n, a_ret_full_n, b_fwd_full_n, b_ret_full_n;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] fwd_q[$];
  logic [W-1:0] ret_q[$];

  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  mbx_bridge uut (.*);

  function automatic logic [W-1:0] keep_bits(input logic [1:0] sz, input logic [W-1:0] d);
    int n;
    n = (sz == 2'b00) ? 36 : (sz == 2'b01) ? 18 : 9;
    for (int i = 0; i < W; i++) if (i >= n) d[i] = 1'b0;
    return d;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // driver: port A writes forward register
  task automatic a_put(input logic [W-1:0] d);
    @(negedge clk_a);
    if (a_fwd_full_n) fwd_q.push_back(keep_bits(bus_size, d));
    a_en = 1; a_write = 1; a_mbsel = 1; a_din = d;
    @(negedge clk_a);
    a_en = 0; a_write = 0;
    chk("R2 fwd writer flag", {35'd0, a_fwd_full_n}, '0);
  endtask

  // monitor: port B takes forward word
  task automatic b_take();
    logic [W-1:0] e;
    b_mbsel = 1;
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    chk("R4 fwd reader flag", {35'd0, b_fwd_full_n}, '0);
    e = fwd_q.pop_front();
    chk("R8 fwd data", b_dout, e);
    b_en = 1; b_write = 0;
    @(negedge clk_b);
    b_en = 0;
    chk("R5 fwd reader release", {35'd0, b_fwd_full_n}, 36'd1);
    chk("R6 fwd data kept", b_dout, e);
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    chk("R5 fwd writer release", {35'd0, a_fwd_full_n}, 36'd1);
  endtask

  task automatic b_put(input logic [W-1:0] d);
    @(negedge clk_b);
    if (b_ret_full_n) ret_q.push_back(keep_bits(bus_size, d));
    b_en = 1; b_write = 1; b_mbsel = 1; b_din = d;
    @(negedge clk_b);
    b_en = 0; b_write = 0;
    chk("R2 ret writer flag", {35'd0, b_ret_full_n}, '0);
  endtask

  task automatic a_take();
    logic [W-1:0] e;
    a_mbsel = 1;
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    chk("R4 ret reader flag", {35'd0, a_ret_full_n}, '0);
    e = ret_q.pop_front();
    chk("R8 ret data", a_dout, e);
    a_en = 1; a_write = 0;
    @(negedge clk_a);
    a_en = 0;
    chk("R5 ret reader release", {35'd0, a_ret_full_n}, 36'd1);
    chk("R6 ret data kept", a_dout, e);
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    chk("R5 ret writer release", {35'd0, b_ret_full_n}, 36'd1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_b);
    rst_n = 1;
    a_mbsel = 1; b_mbsel = 1;
    @(negedge clk_a);
    // R1 reset state
    chk("R1 flags", {32'd0, a_fwd_full_n, a_ret_full_n, b_fwd_full_n, b_ret_full_n}, 36'hF);
    chk("R1 a mail zero", a_dout, '0);
    chk("R1 b mail zero", b_dout, '0);

    a_put(36'h9_1234_5678);
    b_take();
    b_put(36'hA_CAFE_F00D);
    a_take();

    // R3: second write into a full register is dropped
    a_put(36'h1_1111_1111);
    a_put(36'h2_2222_2222);
    b_take();
    b_put(36'h3_3333_3333);
    b_put(36'h4_4444_4444);
    a_take();

    // R7 steering to FIFO word
    a_mbsel = 0; b_mbsel = 0; a_fifo_q = 36'h5_0A0A_0A0A; b_fifo_q = 36'h6_0B0B_0B0B;
    @(negedge clk_a);
    chk("R7 a steer", a_dout, 36'h5_0A0A_0A0A);
    @(negedge clk_b);
    chk("R7 b steer", b_dout, 36'h6_0B0B_0B0B);

    // R8 narrow widths
    bus_size = 2'b01;
    a_put('1);  b_take();
    b_put(36'hF_FFFF_FFFF); a_take();
    bus_size = 2'b10;
    a_put(36'h7_89AB_CDEF); b_take();
    bus_size = 2'b11;
    b_put('1); a_take();
    bus_size = 2'b00;

    // R9 reset while holding a word
    a_put(36'h8_8888_8888);
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    rst_n = 0;
    #1;
    chk("R9 flags", {34'd0, a_fwd_full_n, b_fwd_full_n}, 36'h3);
    chk("R9 cleared", b_dout, '0);
    @(negedge clk_a);
    rst_n = 1;
    void'(fwd_q.pop_front());

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule